// File: doc/BRIEF.md
# Packed SIMD Register File with Lane-Partitioned Adder

This block holds eight 80-bit registers that serve two mutually exclusive contexts: a scalar floating-point context, which stores and fetches whole 80-bit values, and a packed-integer context. In the packed context only the low 64 bits of a register form the operand. That operand is split into lanes of 8, 16, 32 or 64 bits, and one operation acts on every lane at once. A lane-partitioned adder performs wrap-around add, wrap-around subtract and unsigned saturating add. Carries and borrows never cross a lane edge. Results are registered and written back to a destination register.

A mode tracker remembers which context last used the file. An access from the other context is refused with a one-cycle conflict pulse, and the file is left untouched. Only an explicit clear command zeroes all registers and returns the tracker to idle, after which either context may begin. The read port is a neutral save path: it works in every mode and never causes a conflict.

Top module: `pkrf_top`

## Requirements
- R1: After reset every register reads as zero, `modeOut` is 00 (idle), and `resValid` and `conflictErr` are low.
- R2: The write port with `regWrKind`=0 (floating-point) stores all 80 bits of `regWrData` when the mode is idle or floating-point, and sets the mode to 01. With `regWrKind`=1 (packed) it stores `regWrData[63:0]` with bits [79:64] forced to all ones, when the mode is idle or packed, and sets the mode to 10.
- R3: A read request returns, one cycle later on `regRdData`, the full 80-bit register content as it stood before that edge. Reads are allowed in every mode and never raise a conflict.
- R4: An operation (`opValid`, with `opCode` 00=add, 01=subtract, 10=unsigned saturating add) accepted in idle or packed mode sets the mode to 10. One cycle later it presents the 64-bit result on `resData` with `resValid` high, and stores {16'hFFFF, result} in register `opDst`. Operands are bits [63:0] of `opSrcA` and `opSrcB`.
- R5: `laneSize` selects the lane width (00=8, 01=16, 10=32, 11=64 bits). No carry crosses a lane boundary.
- R6: Subtract computes A minus B modulo 2^w in each lane, and no borrow crosses a lane boundary.
- R7: Saturating add sets a lane to all ones when its unsigned sum exceeds the lane's range. Otherwise it gives the plain sum.
- R8: An operation issued while the mode is 01 raises `conflictErr` for one cycle. It produces no `resValid`, changes no register and leaves the mode as it was.
- R9: A floating-point write while the mode is 10, or a packed write while the mode is 01, raises `conflictErr` for one cycle and changes no register or mode.
- R10: `opCode` 11 with `opValid` (clear) zeroes all registers and sets the mode to 00 without raising a conflict. A write in the same cycle is dropped.
- R11: A write and a non-clear operation presented in the same cycle raise `conflictErr`, and neither takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Write request |
| regWrKind | input | 1 | 0 = floating-point write, 1 = packed write |
| regWrIdx | input | 3 | Register to write |
| regWrData | input | 80 | Write data |
| regRdEn | input | 1 | Read request |
| regRdIdx | input | 3 | Register to read |
| regRdData | output | 80 | Read data, one cycle after request |
| opValid | input | 1 | Operation request |
| opCode | input | 2 | 00 add, 01 sub, 10 saturating add, 11 clear |
| laneSize | input | 2 | Lane width select |
| opSrcA | input | 3 | First operand register |
| opSrcB | input | 3 | Second operand register |
| opDst | input | 3 | Destination register |
| resValid | output | 1 | Result valid pulse |
| resData | output | 64 | Packed result |
| conflictErr | output | 1 | Mode conflict pulse |
| modeOut | output | 2 | 00 idle, 01 floating-point, 10 packed |

## Verification
The assertions check the mode rules on every cycle. A clear always leads to idle. An operation in floating-point mode, a floating-point write in packed mode, and any write issued together with an operation each lead to a conflict pulse with no result. A conflict never moves the mode, a result appears only in packed mode, and a result and a conflict never coincide. Only the bench scenarios can show the arithmetic: lane isolation for each width, borrow cut-off in subtraction, saturation limits, the tag bits on packed write-back, and that a refused access or a clear leaves the exact register contents the requirements predict.

// File: rtl/pkrf_pkg.sv
package pkrf_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'b00,
    MODE_FP   = 2'b01,
    MODE_PK   = 2'b10
  } mode_e;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_SATA = 2'b10,
    OP_CLR  = 2'b11
  } op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAll;
    logic wrFp;
    logic wrPk;
    logic opGo;
  } ctrl_t;

endpackage

// File: rtl/pkrf_ctrl.sv
module pkrf_ctrl
  import pkrf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic       regWrKind,
  input  logic       opValid,
  input  logic [1:0] opCode,
  output ctrl_t      ctl,
  output logic       conflictErr,
  output logic [1:0] modeOut
);

  mode_e modeQ, modeD;
  logic  conflictD;
  logic  isClr, isOp;

  assign isClr = opValid && (opCode == OP_CLR);
  assign isOp  = opValid && (opCode != OP_CLR);

  always_comb begin
    ctl       = '0;
    modeD     = modeQ;
    conflictD = 1'b0;
    if (isClr) begin
      ctl.clrAll = 1'b1;
      modeD      = MODE_IDLE;
    end else if (isOp && regWrEn) begin
      conflictD = 1'b1;
    end else if (isOp) begin
      if (modeQ == MODE_FP) begin
        conflictD = 1'b1;
      end else begin
        ctl.opGo = 1'b1;
        modeD    = MODE_PK;
      end
    end else if (regWrEn) begin
      if (regWrKind) begin
        if (modeQ == MODE_FP) begin
          conflictD = 1'b1;
        end else begin
          ctl.wrPk = 1'b1;
          modeD    = MODE_PK;
        end
      end else begin
        if (modeQ == MODE_PK) begin
          conflictD = 1'b1;
        end else begin
          ctl.wrFp = 1'b1;
          modeD    = MODE_FP;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ       <= MODE_IDLE;
      conflictErr <= 1'b0;
    end else begin
      modeQ       <= modeD;
      conflictErr <= conflictD;
    end
  end

  assign modeOut = modeQ;

endmodule

// File: rtl/pkrf_lane_alu.sv
module pkrf_lane_alu #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              doSub,
  input  logic              doSat,
  input  logic [1:0]        laneSize,
  output logic [DATA_W-1:0] result
);

  localparam int NSEG  = DATA_W / LANE_W;
  localparam int IDX_W = (NSEG > 1) ? $clog2(NSEG) : 1;

  logic [IDX_W-1:0]   grpMask;
  logic [NSEG-1:0]    segCarry;
  logic [NSEG-1:0]    laneOvf;
  logic [DATA_W-1:0]  rawSum;

  // segments per lane minus one, used to find lane edges
  always_comb grpMask = IDX_W'((32'd1 << laneSize) - 32'd1);

  always_comb begin
    logic          carry;
    logic          startSeg;
    logic [LANE_W:0] segSum;
    carry    = doSub;
    segCarry = '0;
    rawSum   = '0;
    for (int i = 0; i < NSEG; i++) begin
      startSeg = ((IDX_W'(i) & grpMask) == '0);
      if (startSeg) carry = doSub;
      segSum = {1'b0, opA[i*LANE_W +: LANE_W]}
             + {1'b0, opB[i*LANE_W +: LANE_W] ^ {LANE_W{doSub}}}
             + (LANE_W+1)'(carry);
      rawSum[i*LANE_W +: LANE_W] = segSum[LANE_W-1:0];
      carry       = segSum[LANE_W];
      segCarry[i] = segSum[LANE_W];
    end
  end

  // each segment takes the carry out of the top segment of its lane
  generate
    for (genvar g = 0; g < NSEG; g++) begin : g_ovf
      logic [IDX_W-1:0] topSeg;
      assign topSeg     = IDX_W'(g) | grpMask;
      assign laneOvf[g] = segCarry[topSeg];
      assign result[g*LANE_W +: LANE_W] =
        (doSat && !doSub && laneOvf[g]) ? {LANE_W{1'b1}} : rawSum[g*LANE_W +: LANE_W];
    end
  endgenerate

endmodule

// File: rtl/pkrf_dpath.sv
module pkrf_dpath
  import pkrf_pkg::*;
#(
  parameter int NREGS  = 8,
  parameter int REG_W  = 80,
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  localparam int IDX_W = $clog2(NREGS),
  localparam int TAG_W = REG_W - DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctl,
  input  logic [IDX_W-1:0]  regWrIdx,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              regRdEn,
  input  logic [IDX_W-1:0]  regRdIdx,
  output logic [REG_W-1:0]  regRdData,
  input  logic [1:0]        opCode,
  input  logic [1:0]        laneSize,
  input  logic [IDX_W-1:0]  opSrcA,
  input  logic [IDX_W-1:0]  opSrcB,
  input  logic [IDX_W-1:0]  opDst,
  output logic              resValid,
  output logic [DATA_W-1:0] resData
);

  logic [REG_W-1:0]  regs [NREGS];
  logic [DATA_W-1:0] aluOut;
  logic [DATA_W-1:0] srcAVal, srcBVal;

  assign srcAVal = regs[opSrcA][DATA_W-1:0];
  assign srcBVal = regs[opSrcB][DATA_W-1:0];

  pkrf_lane_alu #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_alu (
    .opA      (srcAVal),
    .opB      (srcBVal),
    .doSub    (opCode == OP_SUB),
    .doSat    (opCode == OP_SATA),
    .laneSize (laneSize),
    .result   (aluOut)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < NREGS; r++) regs[r] <= '0;
      regRdData <= '0;
      resValid  <= 1'b0;
      resData   <= '0;
    end else begin
      resValid <= ctl.opGo;
      if (ctl.opGo) resData <= aluOut;
      if (regRdEn) regRdData <= regs[regRdIdx];
      if (ctl.clrAll) begin
        for (int r = 0; r < NREGS; r++) regs[r] <= '0;
      end else if (ctl.wrFp) begin
        regs[regWrIdx] <= regWrData;
      end else if (ctl.wrPk) begin
        regs[regWrIdx] <= {{TAG_W{1'b1}}, regWrData[DATA_W-1:0]};
      end else if (ctl.opGo) begin
        regs[opDst] <= {{TAG_W{1'b1}}, aluOut};
      end
    end
  end

endmodule

// File: rtl/pkrf_top.sv
module pkrf_top
  import pkrf_pkg::*;
#(
  parameter int NREGS  = 8,
  parameter int REG_W  = 80,
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regWrKind,
  input  logic [IDX_W-1:0]  regWrIdx,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              regRdEn,
  input  logic [IDX_W-1:0]  regRdIdx,
  output logic [REG_W-1:0]  regRdData,
  input  logic              opValid,
  input  logic [1:0]        opCode,
  input  logic [1:0]        laneSize,
  input  logic [IDX_W-1:0]  opSrcA,
  input  logic [IDX_W-1:0]  opSrcB,
  input  logic [IDX_W-1:0]  opDst,
  output logic              resValid,
  output logic [DATA_W-1:0] resData,
  output logic              conflictErr,
  output logic [1:0]        modeOut
);

  ctrl_t ctl;

  pkrf_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .regWrKind   (regWrKind),
    .opValid     (opValid),
    .opCode      (opCode),
    .ctl         (ctl),
    .conflictErr (conflictErr),
    .modeOut     (modeOut)
  );

  pkrf_dpath #(
    .NREGS(NREGS), .REG_W(REG_W), .DATA_W(DATA_W), .LANE_W(LANE_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .regWrIdx  (regWrIdx),
    .regWrData (regWrData),
    .regRdEn   (regRdEn),
    .regRdIdx  (regRdIdx),
    .regRdData (regRdData),
    .opCode    (opCode),
    .laneSize  (laneSize),
    .opSrcA    (opSrcA),
    .opSrcB    (opSrcB),
    .opDst     (opDst),
    .resValid  (resValid),
    .resData   (resData)
  );

endmodule

// File: rtl/pkrf_check.sv
module pkrf_check #(
  parameter int NREGS  = 8,
  parameter int REG_W  = 80,
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  localparam int IDX_W = $clog2(NREGS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              regWrKind,
  input logic [IDX_W-1:0]  regWrIdx,
  input logic [REG_W-1:0]  regWrData,
  input logic              regRdEn,
  input logic [IDX_W-1:0]  regRdIdx,
  input logic [REG_W-1:0]  regRdData,
  input logic              opValid,
  input logic [1:0]        opCode,
  input logic [1:0]        laneSize,
  input logic [IDX_W-1:0]  opSrcA,
  input logic [IDX_W-1:0]  opSrcB,
  input logic [IDX_W-1:0]  opDst,
  input logic              resValid,
  input logic [DATA_W-1:0] resData,
  input logic              conflictErr,
  input logic [1:0]        modeOut
);

  p_clear_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 2'b11) |=> (modeOut == 2'b00 && !conflictErr && !resValid));

  p_op_in_fp_r8: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'b01 && opValid && opCode != 2'b11) |=> (conflictErr && !resValid));

  p_fp_in_pk_r9: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'b10 && regWrEn && !regWrKind && !opValid) |=> conflictErr);

  p_wr_and_op_r11: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && opValid && opCode != 2'b11) |=> (conflictErr && !resValid));

  p_mode_kept_r8: assert property (@(posedge clk) disable iff (!rstN)
    conflictErr |-> (modeOut == $past(modeOut)));

  p_res_in_pk_r4: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (modeOut == 2'b10));

  p_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({resValid, conflictErr}));

endmodule

bind pkrf_top pkrf_check u_chk (.*);

// File: tb/sim_pkrf_top.sv
module sim_pkrf_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regWrKind = 1'b0;
  logic [2:0]  regWrIdx = '0;
  logic [79:0] regWrData = '0;
  logic        regRdEn = 1'b0;
  logic [2:0]  regRdIdx = '0;
  logic [79:0] regRdData;
  logic        opValid = 1'b0;
  logic [1:0]  opCode = '0, laneSize = '0;
  logic [2:0]  opSrcA = '0, opSrcB = '0, opDst = '0;
  logic        resValid;
  logic [63:0] resData;
  logic        conflictErr;
  logic [1:0]  modeOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [79:0] mregs [8];
  logic [63:0] expQ [$];

  always #2.5 clk = ~clk;

  pkrf_top u0 (.*);

  task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic [1:0] op, input logic [1:0] ls);
    int w;
    logic [63:0] r;
    w = 8 << ls;
    r = '0;
    for (int l = 0; l < 64 / w; l++) begin
      logic [64:0] m, x, y, s;
      m = {1'b0, {64{1'b1}} >> (64 - w)};
      x = {1'b0, a >> (l * w)} & m;
      y = {1'b0, b >> (l * w)} & m;
      if (op == 2'b01) s = (x - y) & m;
      else begin
        s = x + y;
        if (op == 2'b10 && s > m) s = m;
        s = s & m;
      end
      r = r | (s[63:0] << (l * w));
    end
    return r;
  endfunction

  // monitor: pops the scoreboard as results appear
  always @(posedge clk) begin
    #1;
    if (rstN && resValid) begin
      if (expQ.size() == 0) check("R4 unexpected result", {16'h0, resData}, 80'h0);
      else check("R4/R5/R6/R7 result", {16'h0, resData}, {16'h0, expQ.pop_front()});
    end
  end

  task automatic wr(input logic kind, input logic [2:0] idx, input logic [79:0] d,
                    input bit expConf, input string req);
    @(negedge clk);
    regWrEn = 1'b1; regWrKind = kind; regWrIdx = idx; regWrData = d;
    if (!expConf) mregs[idx] = kind ? {16'hFFFF, d[63:0]} : d;
    @(negedge clk);
    regWrEn = 1'b0;
    check(req, {79'h0, conflictErr}, {79'h0, expConf});
  endtask

  task automatic rdChk(input logic [2:0] idx, input string req);
    @(negedge clk);
    regRdEn = 1'b1; regRdIdx = idx;
    @(negedge clk);
    regRdEn = 1'b0;
    check(req, regRdData, mregs[idx]);
    check("R3 read never conflicts", {79'h0, conflictErr}, 80'h0);
  endtask

  task automatic doOp(input logic [1:0] op, input logic [1:0] ls, input logic [2:0] a,
                      input logic [2:0] b, input logic [2:0] d, input bit expConf,
                      input string req);
    logic [63:0] r;
    @(negedge clk);
    opValid = 1'b1; opCode = op; laneSize = ls; opSrcA = a; opSrcB = b; opDst = d;
    if (!expConf) begin
      r = model(mregs[a][63:0], mregs[b][63:0], op, ls);
      expQ.push_back(r);
      mregs[d] = {16'hFFFF, r};
    end
    @(negedge clk);
    opValid = 1'b0;
    check(req, {79'h0, conflictErr}, {79'h0, expConf});
    if (expConf) check("R8 no result on conflict", {79'h0, resValid}, 80'h0);
  endtask

  task automatic doClr(input bit withWr);
    @(negedge clk);
    opValid = 1'b1; opCode = 2'b11;
    regWrEn = withWr; regWrKind = 1'b0; regWrIdx = 3'd5; regWrData = 80'h1234;
    for (int i = 0; i < 8; i++) mregs[i] = '0;
    @(negedge clk);
    opValid = 1'b0; regWrEn = 1'b0;
    check("R10 clear mode idle", {78'h0, modeOut}, 80'h0);
    check("R10 clear no conflict", {79'h0, conflictErr}, 80'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) mregs[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 mode idle", {78'h0, modeOut}, 80'h0);
    check("R1 no result", {79'h0, resValid}, 80'h0);
    check("R1 no conflict", {79'h0, conflictErr}, 80'h0);
    for (int i = 0; i < 8; i++) rdChk(3'(i), "R1 reg zero");

    // R2 floating-point writes
    wr(1'b0, 3'd0, 80'hABCD_1122_3344_5566_7788, 1'b0, "R2 fp write ok");
    wr(1'b0, 3'd1, 80'h7FFF_0000_0000_0000_0001, 1'b0, "R2 fp write ok");
    check("R2 mode fp", {78'h0, modeOut}, 80'h1);
    rdChk(3'd0, "R3 read full 80 bits");
    // R8 packed op in fp mode
    doOp(2'b00, 2'b00, 3'd0, 3'd1, 3'd2, 1'b1, "R8 op in fp mode conflicts");
    check("R8 mode kept", {78'h0, modeOut}, 80'h1);
    rdChk(3'd2, "R8 dst unchanged");
    // R9 packed write in fp mode
    wr(1'b1, 3'd3, 80'h55, 1'b1, "R9 packed write in fp mode conflicts");
    rdChk(3'd3, "R9 reg unchanged");
    // R10 clear
    doClr(1'b0);
    for (int i = 0; i < 8; i++) rdChk(3'(i), "R10 regs zeroed");

    // packed loads
    wr(1'b1, 3'd0, 80'h0000_FFFF_FFFF_FFFF_FFFF, 1'b0, "R2 packed write ok");
    wr(1'b1, 3'd1, 80'h1234_0000_0000_0000_0001, 1'b0, "R2 packed write ok");
    wr(1'b1, 3'd2, 80'h0000_0101_0101_0101_0101, 1'b0, "R2 packed write ok");
    wr(1'b1, 3'd3, 80'h0000_80F0_7FFF_C000_9001, 1'b0, "R2 packed write ok");
    check("R2 mode packed", {78'h0, modeOut}, 80'h2);
    rdChk(3'd1, "R2 packed tag ones");
    // R5 lane isolation, all-ones plus one per lane size
    for (int ls = 0; ls < 4; ls++) doOp(2'b00, 2'(ls), 3'd0, 3'd1, 3'd4, 1'b0, "R5 add");
    for (int ls = 0; ls < 4; ls++) doOp(2'b00, 2'(ls), 3'd0, 3'd2, 3'd4, 1'b0, "R5 add");
    // R6 subtract with borrows
    for (int ls = 0; ls < 4; ls++) doOp(2'b01, 2'(ls), 3'd1, 3'd2, 3'd5, 1'b0, "R6 sub");
    for (int ls = 0; ls < 4; ls++) doOp(2'b01, 2'(ls), 3'd3, 3'd0, 3'd5, 1'b0, "R6 sub");
    // R7 saturating add
    for (int ls = 0; ls < 4; ls++) doOp(2'b10, 2'(ls), 3'd3, 3'd3, 3'd6, 1'b0, "R7 sat");
    for (int ls = 0; ls < 4; ls++) doOp(2'b10, 2'(ls), 3'd0, 3'd2, 3'd6, 1'b0, "R7 sat");
    doOp(2'b10, 2'b00, 3'd1, 3'd2, 3'd7, 1'b0, "R7 sat no overflow");
    // R4 chained write-back
    doOp(2'b00, 2'b01, 3'd7, 3'd3, 3'd7, 1'b0, "R4 chained");
    rdChk(3'd7, "R4 dst tag and value");
    rdChk(3'd6, "R4 dst tag and value");
    // R9 fp write in packed mode
    wr(1'b0, 3'd7, 80'h9, 1'b1, "R9 fp write in packed mode conflicts");
    check("R9 mode kept", {78'h0, modeOut}, 80'h2);
    rdChk(3'd7, "R9 reg unchanged");
    // R11 write together with op
    @(negedge clk);
    regWrEn = 1'b1; regWrKind = 1'b1; regWrIdx = 3'd4; regWrData = 80'h77;
    opValid = 1'b1; opCode = 2'b00; laneSize = 2'b00; opSrcA = 3'd0; opSrcB = 3'd0; opDst = 3'd5;
    @(negedge clk);
    regWrEn = 1'b0; opValid = 1'b0;
    check("R11 conflict", {79'h0, conflictErr}, 80'h1);
    check("R11 no result", {79'h0, resValid}, 80'h0);
    rdChk(3'd4, "R11 write dropped");
    rdChk(3'd5, "R11 op dropped");
    // R10 clear dominates a same-cycle write, then fp use may start
    doClr(1'b1);
    rdChk(3'd5, "R10 write dropped under clear");
    wr(1'b0, 3'd2, 80'hFEED_0000_0000_0000_BEEF, 1'b0, "R10 fp after clear");
    rdChk(3'd2, "R10 fp data");

    repeat (3) @(negedge clk);
    check("R4 scoreboard drained", 80'(expQ.size()), 80'h0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule